// File: doc/BRIEF.md
# Secure RAM Configuration Register Bank

This block holds the configuration state of a secure RAM controller: a module enable, three mode bits (erase on tamper, periodic remanence refresh, complement-pair access), a scramble enable and a scramble key. It also owns the word storage of the secure RAM itself. Software reaches all of it through a plain register write port and a registered read port. Every field that shapes how the RAM is encoded is locked while the module runs. Writes that hit a locked field are dropped without any error.

The block drives a scrambling-active flag for the datapath. The flag is the AND of the module enable and the stored scramble enable. When the tamper input is seen while erase-on-tamper is armed, the block clears the key and all control state in one edge. It then walks through every RAM word, writing zero, and holds a busy flag until the last word is cleared. No software action is needed for this erase.

Top module: `secram_cfg_bank`

## Requirements
- R1: After reset the module enable, all three mode bits, the scramble enable, the key, the busy flag, the scrambling-active flag and the read data are all zero.
- R2: The mode bits (write data bit 1 erase-on-tamper, bit 2 remanence, bit 3 complement access, at register address 0) change only in a write issued while the module enable is 0, and this includes the write that sets the enable (bit 0) to 1. A control write made while enabled may clear the enable, but it leaves the mode bits as they were.
- R3: The scramble-enable register (address 1, bit 0), the key register (address 2) and every RAM word (addresses with the top address bit set, word index in the lower bits) take a write only while the module enable is 0. Writes made while enabled are ignored and raise no error.
- R4: The scrambling-active output is 1 exactly when both the module enable and the scramble enable are 1. Clearing the module enable drops the output but keeps the stored scramble enable, which reads back unchanged.
- R5: The read data shows the addressed location one cycle after a read request and holds it otherwise. Address 0 returns {busy, complement, remanence, erase-on-tamper, enable} in bits 4..0. Unmapped register addresses return zero.
- R6: When the tamper input is high at a clock edge while erase-on-tamper is 1 and no erase is running, that edge clears the enable, the mode bits, the scramble enable and the key, and raises busy.
- R7: Busy stays high for exactly as many cycles as there are RAM words. When it falls, every RAM word reads zero.
- R8: The tamper input has no effect while erase-on-tamper is 0.
- R9: While busy is high, all register and RAM writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write request |
| wr_addr_i | input | AW (7) | Write address |
| wr_data_i | input | DW (32) | Write data |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | AW (7) | Read address |
| rd_data_o | output | DW (32) | Registered read data |
| tamper_i | input | 1 | Tamper event |
| module_en_o | output | 1 | Module enable |
| tamper_erase_en_o | output | 1 | Erase-on-tamper mode |
| remanence_en_o | output | 1 | Remanence refresh mode |
| compl_access_en_o | output | 1 | Complement-pair access mode |
| scramble_active_o | output | 1 | Scrambling in effect |
| scramble_key_o | output | KW (32) | Scramble key |
| busy_o | output | 1 | Tamper erase running |

## Verification
Register writes and the tamper response take effect at the first clock edge after the request, and read data lands one edge after the read request. The bench drives every input just after a falling edge and samples at the next falling edge, so each result is checked in the cycle it is due. Busy is sampled at every falling edge after a tamper event, and the count of high samples must equal the word count. The RAM is read back only after busy has fallen.

// File: rtl/secram_cfg_pkg.sv
package secram_cfg_pkg;

  // Mode fields, packed so that {compl_acc, reman, terase} maps to ctrl bits 3..1
  typedef struct packed {
    logic compl_acc;
    logic reman;
    logic terase;
  } mode_t;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MODE_LSB = 1;
  localparam int unsigned CTRL_BUSY_BIT = 4;

  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_SCR  = 1;
  localparam int unsigned REG_KEY  = 2;

endpackage

// File: rtl/secram_cfg_ctrl.sv
module secram_cfg_ctrl
  import secram_cfg_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned KW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic          sel_ctrl,
  input  logic          sel_scr,
  input  logic          sel_key,
  input  logic [DW-1:0] wr_data,
  input  logic          erase_start,
  output logic          en_q,
  output mode_t         mode_q,
  output logic          scr_en_q,
  output logic [KW-1:0] key_q
);

  logic          en_d;
  mode_t         mode_d;
  logic          scr_en_d;
  logic [KW-1:0] key_d;
  logic          unlocked;

  assign unlocked = ~en_q;

  // next state
  always_comb begin
    en_d     = en_q;
    mode_d   = mode_q;
    scr_en_d = scr_en_q;
    key_d    = key_q;
    if (erase_start) begin
      en_d     = 1'b0;
      mode_d   = '0;
      scr_en_d = 1'b0;
      key_d    = '0;
    end else if (wr_ok) begin
      if (sel_ctrl) begin
        en_d = wr_data[CTRL_EN_BIT];
        // mode bits only accepted while currently disabled (covers enable-setting write)
        if (unlocked) mode_d = mode_t'(wr_data[CTRL_MODE_LSB +: 3]);
      end
      if (sel_scr && unlocked) scr_en_d = wr_data[0];
      if (sel_key && unlocked) key_d    = wr_data[KW-1:0];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      mode_q   <= '0;
      scr_en_q <= 1'b0;
      key_q    <= '0;
    end else begin
      en_q     <= en_d;
      mode_q   <= mode_d;
      scr_en_q <= scr_en_d;
      key_q    <= key_d;
    end
  end

endmodule

// File: rtl/secram_erase_seq.sv
module secram_erase_seq #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy_q,
  output logic          clr_we,
  output logic [IW-1:0] clr_idx
);

  localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

  logic          busy_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (idx_q == LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign clr_we  = busy_q;
  assign clr_idx = idx_q;

endmodule

// File: rtl/secram_word_store.sv
module secram_word_store #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  // storage array carries no reset; contents are defined by writes or erase
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/secram_cfg_bank.sv
module secram_cfg_bank
  import secram_cfg_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 32,
  parameter int unsigned KW    = 32,
  localparam int unsigned IW   = $clog2(WORDS),
  localparam int unsigned AW   = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          tamper_i,
  output logic          module_en_o,
  output logic          tamper_erase_en_o,
  output logic          remanence_en_o,
  output logic          compl_access_en_o,
  output logic          scramble_active_o,
  output logic [KW-1:0] scramble_key_o,
  output logic          busy_o
);

  localparam logic [IW-1:0] A_CTRL = IW'(REG_CTRL);
  localparam logic [IW-1:0] A_SCR  = IW'(REG_SCR);
  localparam logic [IW-1:0] A_KEY  = IW'(REG_KEY);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          en_q, scr_en_q, busy_q, erase_start, wr_ok;
  mode_t         mode_q;
  logic [KW-1:0] key_q;
  logic          wr_is_ram, sel_ctrl, sel_scr, sel_key;
  logic          clr_we, ram_we;
  logic [IW-1:0] clr_idx, ram_waddr;
  logic [DW-1:0] ram_wdata, ram_rdata;

  // write decode
  assign wr_is_ram = wr_addr_i[AW-1];
  assign sel_ctrl  = ~wr_is_ram && (wr_addr_i[IW-1:0] == A_CTRL);
  assign sel_scr   = ~wr_is_ram && (wr_addr_i[IW-1:0] == A_SCR);
  assign sel_key   = ~wr_is_ram && (wr_addr_i[IW-1:0] == A_KEY);
  assign wr_ok     = wr_en_i & ~busy_q;

  assign erase_start = tamper_i & mode_q.terase & ~busy_q;

  secram_cfg_ctrl #(.DW(DW), .KW(KW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_ok      (wr_ok),
    .sel_ctrl   (sel_ctrl),
    .sel_scr    (sel_scr),
    .sel_key    (sel_key),
    .wr_data    (wr_data_i),
    .erase_start(erase_start),
    .en_q       (en_q),
    .mode_q     (mode_q),
    .scr_en_q   (scr_en_q),
    .key_q      (key_q)
  );

  secram_erase_seq #(.WORDS(WORDS)) u_erase (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (erase_start),
    .busy_q (busy_q),
    .clr_we (clr_we),
    .clr_idx(clr_idx)
  );

  // RAM write arbitration: erase sweep owns the port while busy
  always_comb begin
    if (clr_we) begin
      ram_we    = 1'b1;
      ram_waddr = clr_idx;
      ram_wdata = '0;
    end else begin
      ram_we    = wr_ok & wr_is_ram & ~en_q;
      ram_waddr = wr_addr_i[IW-1:0];
      ram_wdata = wr_data_i;
    end
  end

  secram_word_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .raddr(rd_addr_i[IW-1:0]),
    .rdata(ram_rdata)
  );

  // read path
  logic [DW-1:0] rd_mux, rd_q, rd_d;

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i[AW-1]) begin
      rd_mux = ram_rdata;
    end else if (rd_addr_i[IW-1:0] == A_CTRL) begin
      rd_mux[CTRL_EN_BIT]              = en_q;
      rd_mux[CTRL_MODE_LSB +: 3]       = mode_q;
      rd_mux[CTRL_BUSY_BIT]            = busy_q;
    end else if (rd_addr_i[IW-1:0] == A_SCR) begin
      rd_mux[0] = scr_en_q;
    end else if (rd_addr_i[IW-1:0] == A_KEY) begin
      rd_mux[KW-1:0] = key_q;
    end
  end

  assign rd_d = rd_en_i ? rd_mux : rd_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_q <= '0;
    else            rd_q <= rd_d;
  end

  assign rd_data_o         = rd_q;
  assign module_en_o       = en_q;
  assign tamper_erase_en_o = mode_q.terase;
  assign remanence_en_o    = mode_q.reman;
  assign compl_access_en_o = mode_q.compl_acc;
  assign scramble_active_o = en_q & scr_en_q;
  assign scramble_key_o    = key_q;
  assign busy_o            = busy_q;

endmodule

// File: rtl/secram_cfg_bank_chk.sv
module secram_cfg_bank_chk #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned KW    = 32,
  localparam int unsigned CW   = $clog2(WORDS) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tamper_i,
  input logic          module_en_o,
  input logic          tamper_erase_en_o,
  input logic          remanence_en_o,
  input logic          compl_access_en_o,
  input logic          scramble_active_o,
  input logic [KW-1:0] scramble_key_o,
  input logic          busy_o
);

  logic          hit;
  logic [CW-1:0] busy_cnt;

  assign hit = tamper_i & tamper_erase_en_o & ~busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  p_mode_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (module_en_o && !hit) |=> $stable({tamper_erase_en_o, remanence_en_o, compl_access_en_o}));

  p_key_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (module_en_o && !hit) |=> $stable(scramble_key_o));

  p_scr_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scramble_active_o |-> module_en_o);

  p_erase_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (busy_o && !module_en_o && !scramble_active_o && scramble_key_o == '0));

  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_cnt == CW'(WORDS)));

  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_cnt < CW'(WORDS)));

  p_no_tamper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tamper_erase_en_o && !busy_o) |=> !busy_o);

  p_busy_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !module_en_o);

endmodule

bind secram_cfg_bank secram_cfg_bank_chk #(.WORDS(WORDS), .KW(KW)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .tamper_i         (tamper_i),
  .module_en_o      (module_en_o),
  .tamper_erase_en_o(tamper_erase_en_o),
  .remanence_en_o   (remanence_en_o),
  .compl_access_en_o(compl_access_en_o),
  .scramble_active_o(scramble_active_o),
  .scramble_key_o   (scramble_key_o),
  .busy_o           (busy_o)
);

// File: tb/secram_cfg_bank_tb.sv
module secram_cfg_bank_tb;

  localparam int WORDS = 64;
  localparam int DW    = 32;
  localparam int KW    = 32;
  localparam int AW    = 7;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en_i, rd_en_i, tamper_i;
  logic [AW-1:0] wr_addr_i, rd_addr_i;
  logic [DW-1:0] wr_data_i;
  logic [DW-1:0] rd_data_o;
  logic          module_en_o, tamper_erase_en_o, remanence_en_o, compl_access_en_o;
  logic          scramble_active_o, busy_o;
  logic [KW-1:0] scramble_key_o;

  always #5 clk = ~clk;

  secram_cfg_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .tamper_i(tamper_i),
    .module_en_o(module_en_o), .tamper_erase_en_o(tamper_erase_en_o),
    .remanence_en_o(remanence_en_o), .compl_access_en_o(compl_access_en_o),
    .scramble_active_o(scramble_active_o), .scramble_key_o(scramble_key_o),
    .busy_o(busy_o)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model
  logic          m_en, m_scr;
  logic [2:0]    m_mode;
  logic [KW-1:0] m_key;
  logic [DW-1:0] m_ram [WORDS];

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    logic [DW-1:0] v = '0;
    if (a[AW-1]) v = m_ram[a[AW-2:0]];
    else if (a[AW-2:0] == 0) v[4:0] = {1'b0, m_mode, m_en};
    else if (a[AW-2:0] == 1) v[0] = m_scr;
    else if (a[AW-2:0] == 2) v = m_key;
    return v;
  endfunction

  function automatic logic [3:0] exp_ctrl(input logic en, input logic [2:0] md,
                                          input logic [DW-1:0] d);
    return {(en ? md : d[3:1]), d[0]};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (a[AW-1]) begin
      if (!m_en) m_ram[a[AW-2:0]] = d;
    end else if (a[AW-2:0] == 0) begin
      {m_mode, m_en} = exp_ctrl(m_en, m_mode, d);
    end else if (a[AW-2:0] == 1) begin
      if (!m_en) m_scr = d[0];
    end else if (a[AW-2:0] == 2) begin
      if (!m_en) m_key = d;
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    chk(req, rd_data_o, exp_read(a));
  endtask

  task automatic chk_ports(input string req);
    chk(req, {27'd0, scramble_active_o, compl_access_en_o, remanence_en_o,
              tamper_erase_en_o, module_en_o},
        {27'd0, m_en & m_scr, m_mode, m_en});
    chk(req, scramble_key_o, m_key);
  endtask

  task automatic tamper_pulse();
    tamper_i = 1'b1;
    @(negedge clk);
    tamper_i = 1'b0;
  endtask

  task automatic model_erase();
    m_en = 0; m_scr = 0; m_mode = '0; m_key = '0;
    for (int i = 0; i < WORDS; i++) m_ram[i] = '0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    int nb;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0; wr_en_i = 0; rd_en_i = 0; tamper_i = 0;
    wr_addr_i = '0; rd_addr_i = '0; wr_data_i = '0;
    m_en = 0; m_scr = 0; m_mode = '0; m_key = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", {26'd0, busy_o, scramble_active_o, compl_access_en_o, remanence_en_o,
               tamper_erase_en_o, module_en_o}, '0);
    chk("R1", scramble_key_o, '0);
    chk("R1", rd_data_o, '0);

    // fill RAM while disabled
    for (int i = 0; i < WORDS; i++) wr(AW'(64 + i), $urandom);
    for (int i = 0; i < WORDS; i += 9) rd(AW'(64 + i), "R3");

    // R2 directed: enable write carries modes; disable write keeps them
    wr(0, 32'h0000_000F);
    chk_ports("R2");
    wr(0, 32'h0000_0000);
    chk_ports("R2");
    chk("R2", {29'd0, remanence_en_o, compl_access_en_o, tamper_erase_en_o}, 32'd7);
    wr(0, 32'h0000_0001);  // enable only while disabled: modes cleared
    chk_ports("R2");
    wr(0, 32'h0000_000F);  // modes locked while enabled
    chk_ports("R2");
    wr(0, 32'h0000_0000);

    // R4 directed
    wr(1, 32'h1);
    wr(2, 32'hA5C3_0F1E);
    wr(0, 32'h1);
    chk("R4", {31'd0, scramble_active_o}, 32'd1);
    wr(1, 32'h0);                 // ignored (R3)
    chk("R3", {31'd0, scramble_active_o}, 32'd1);
    wr(2, 32'h1234_5678);         // ignored (R3)
    chk_ports("R3");
    wr(AW'(64 + 5), 32'hDEAD_BEEF); // ignored (R3)
    rd(AW'(64 + 5), "R3");
    wr(0, 32'h0);
    chk("R4", {31'd0, scramble_active_o}, 32'd0);
    rd(1, "R4");
    rd(3, "R5");
    rd(0, "R5");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 99);
      if (op < 25)      wr(0, {28'd0, 4'($urandom)});
      else if (op < 35) wr(1, $urandom);
      else if (op < 45) wr(2, $urandom);
      else if (op < 65) wr(AW'(64 + $urandom_range(0, WORDS - 1)), $urandom);
      else              rd(AW'($urandom), "R5");
      chk_ports("R4");
    end

    // R8 tamper ignored without erase mode
    wr(0, 32'h0);
    wr(1, 32'h1);
    wr(0, 32'h1);
    tamper_pulse();
    chk("R8", {31'd0, busy_o}, 32'd0);
    chk_ports("R8");

    // R6/R7 tamper erase
    wr(0, 32'h0);
    wr(2, 32'h0BAD_F00D);
    wr(0, 32'h3);
    chk_ports("R6");
    tamper_pulse();
    model_erase();
    chk("R6", {31'd0, busy_o}, 32'd1);
    chk_ports("R6");
    nb = 1;
    while (busy_o && nb < 200) begin
      @(negedge clk);
      if (busy_o) nb++;
    end
    chk("R7", nb, WORDS);
    for (int i = 0; i < WORDS; i++) rd(AW'(64 + i), "R7");

    // R9 writes ignored while busy
    wr(0, 32'h2);
    wr(0, 32'h3);
    tamper_pulse();
    model_erase();
    wr(2, 32'h7777_7777);
    m_key = '0;
    wr(0, 32'h1);
    m_en = 0;
    chk_ports("R9");
    while (busy_o) @(negedge clk);
    chk_ports("R9");
    rd(0, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

endmodule